// File: doc/BRIEF.md
# Select-Code Service Request and Poll Responder

This block lets a peripheral interface ask a host calculator for service and then identify itself when the calculator polls. A four-bit select code, set by a switch, places the interface in one of two request banks and at one of eight positions within that bank. The processor side raises a request with a single-cycle strobe. The request is latched and shown on the bank's active-low request line until the processor issues a service-clear.

While a request is pending, the calculator may start a poll by pulling an active-low poll input low and naming the bank it is polling. When the polled bank matches the select-code MSB, the block pulls exactly one of eight calculator data lines low. The line index is the lower three select-code bits. Every data line is modelled as an active-low value with a separate drive-enable, and an undriven line reads high.

The control is a three-state machine. `ST_IDLE` means no request. `ST_PEND` means a request is latched and not answering. `ST_ANSWER` means a request is latched and the data line is being driven. The transitions are:

- IDLE→PEND on a strobe while the poll input is high. A strobe during a poll is dropped.
- PEND→ANSWER when a poll is active on the matching bank.
- ANSWER→PEND when the poll ends or the polled bank no longer matches.
- PEND→IDLE and ANSWER→IDLE on service-clear. Service-clear has priority over every other input.

Top module: `irq_poll_responder`

## Requirements
- R1: After reset both request lines are high, `dline_oe` is all zeros and `dline_n` is all ones.
- R2: A `req_strobe` sampled while `poll_n` is 1 and `svc_clear` is 0 latches a request, which shows on a request line from the following clock edge.
- R3: While a request is pending, `req_lo_n` is 0 and `req_hi_n` is 1 when `sel_code[3]` is 0 (codes 0 to 7). When `sel_code[3]` is 1 (codes 8 to 15), `req_hi_n` is 0 and `req_lo_n` is 1. The two lines are never low together.
- R4: A `req_strobe` sampled while `poll_n` is 0 is dropped. The request lines stay high afterwards and nothing is queued.
- R5: A pending request stays latched, whatever the strobe and poll inputs do, until `svc_clear` is sampled high. Both request lines are high from the next edge. `svc_clear` beats a simultaneous strobe.
- R6: With a request pending, a clock edge that samples `poll_n` = 0 and `poll_bank` equal to `sel_code[3]` makes `dline_oe` one-hot at bit `sel_code[2:0]` from that edge on. In that state `dline_n` has a 0 at the same bit, so codes 0 and 8 use line 0 and codes 7 and 15 use line 7.
- R7: No data line is driven when no request is pending, when no poll is in progress, or when `poll_bank` differs from `sel_code[3]`.
- R8: Every data line whose enable is 0 reads 1 on `dline_n`.
- R9: When an edge samples `poll_n` = 1, or a bank mismatch, during an answer, the drive is released from that edge and the request line stays asserted. An edge that samples `svc_clear` during an answer releases both the drive and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_code | input | 4 | Select-code switch setting |
| req_strobe | input | 1 | Processor request strobe, one cycle |
| svc_clear | input | 1 | Processor service-clear |
| poll_n | input | 1 | Calculator poll, active low |
| poll_bank | input | 1 | Bank being polled (0 low, 1 high) |
| req_lo_n | output | 1 | Low-bank request line, active low |
| req_hi_n | output | 1 | High-bank request line, active low |
| dline_n | output | 8 | Data-line values, active low |
| dline_oe | output | 8 | Data-line drive enables |

## Verification
The bench sweeps all sixteen select codes. Pairs that share a line, such as 0 and 8 or 7 and 15, expose a decoder that uses the MSB in the index or a bank selector that ignores it: either fault drives the wrong line or raises the wrong request. It strobes during an active poll, where a design that queued the strobe would raise a request later. It polls the wrong bank, where a loose bank match would drive a line, and it polls with nothing pending, which catches a responder gated only by the poll input. It also asserts clear together with a strobe, where the wrong priority would leave a request latched.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PEND   = 2'd1,
        ST_ANSWER = 2'd2
    } irq_state_e;

    // A poll concerns this device when it is active and the bank agrees.
    function automatic logic poll_hits(input logic poll_n, input logic poll_bank,
                                       input logic bank_msb);
        return (!poll_n) && (poll_bank == bank_msb);
    endfunction

endpackage

// File: rtl/irqp_fsm.sv
module irqp_fsm
    import irqp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_strobe,
    input  logic svc_clear,
    input  logic poll_n,
    input  logic poll_bank,
    input  logic bank_msb,
    output logic pending,
    output logic answering
);

    irq_state_e state_q, state_d;
    logic       hit;

    assign hit = poll_hits(poll_n, poll_bank, bank_msb);

    always_comb begin
        state_d = state_q;
        if (svc_clear) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (req_strobe && poll_n) state_d = ST_PEND;
                ST_PEND:   if (hit)                  state_d = ST_ANSWER;
                ST_ANSWER: if (!hit)                 state_d = ST_PEND;
                default:                             state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending   = 1'b0;
        answering = 1'b0;
        unique case (state_q)
            ST_IDLE:   begin pending = 1'b0; answering = 1'b0; end
            ST_PEND:   begin pending = 1'b1; answering = 1'b0; end
            ST_ANSWER: begin pending = 1'b1; answering = 1'b1; end
            default:   begin pending = 1'b0; answering = 1'b0; end
        endcase
    end

    AST_STROBE_DROPPED_IN_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_strobe && !poll_n) |=> (state_q == ST_IDLE)); // R4
    AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        svc_clear |=> (state_q == ST_IDLE)); // R5
    AST_REQUEST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !svc_clear) |=> (state_q != ST_IDLE)); // R5
    AST_ANSWER_NEEDS_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ANSWER) |-> $past(!poll_n)); // R6
    AST_POLL_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ANSWER && poll_n && !svc_clear) |=> (state_q == ST_PEND)); // R9

endmodule

// File: rtl/irqp_bank_sel.sv
module irqp_bank_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic bank_msb,
    output logic req_lo_n,
    output logic req_hi_n
);

    always_comb begin
        req_lo_n = 1'b1;
        req_hi_n = 1'b1;
        if (pending) begin
            if (bank_msb) req_hi_n = 1'b0;
            else          req_lo_n = 1'b0;
        end
    end

    AST_BANKS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!req_lo_n && !req_hi_n)); // R3

endmodule

// File: rtl/irqp_poll_dec.sv
module irqp_poll_dec #(
    parameter int IDX_W = 3,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             answering,
    input  logic [IDX_W-1:0] idx,
    output logic [LINES-1:0] dline_n,
    output logic [LINES-1:0] dline_oe
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign dline_oe[g] = answering && (idx == IDX_W'(g));
        assign dline_n[g]  = !dline_oe[g];
    end

    AST_AT_MOST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dline_oe)); // R6
    AST_ANSWER_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        answering |-> ($countones(dline_oe) == 1)); // R6

endmodule

// File: rtl/irq_poll_responder.sv
module irq_poll_responder #(
    parameter int SEL_W = 4,
    localparam int IDX_W = SEL_W - 1,
    localparam int LINES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_code,
    input  logic             req_strobe,
    input  logic             svc_clear,
    input  logic             poll_n,
    input  logic             poll_bank,
    output logic             req_lo_n,
    output logic             req_hi_n,
    output logic [LINES-1:0] dline_n,
    output logic [LINES-1:0] dline_oe
);

    logic pending;
    logic answering;
    logic bank_msb;

    assign bank_msb = sel_code[SEL_W-1];

    irqp_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_strobe (req_strobe),
        .svc_clear  (svc_clear),
        .poll_n     (poll_n),
        .poll_bank  (poll_bank),
        .bank_msb   (bank_msb),
        .pending    (pending),
        .answering  (answering)
    );

    irqp_bank_sel u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pending  (pending),
        .bank_msb (bank_msb),
        .req_lo_n (req_lo_n),
        .req_hi_n (req_hi_n)
    );

    irqp_poll_dec #(.IDX_W(IDX_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .answering (answering),
        .idx       (sel_code[IDX_W-1:0]),
        .dline_n   (dline_n),
        .dline_oe  (dline_oe)
    );

    AST_QUIET_WITHOUT_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_lo_n && req_hi_n) |-> (dline_oe == '0)); // R7
    AST_UNDRIVEN_READS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((dline_n | dline_oe) == {LINES{1'b1}})); // R8

endmodule

// File: tb/irq_poll_responder_bench.sv
module irq_poll_responder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel_code = 4'd0;
    logic       req_strobe = 1'b0;
    logic       svc_clear = 1'b0;
    logic       poll_n = 1'b1;
    logic       poll_bank = 1'b0;
    logic       req_lo_n, req_hi_n;
    logic [7:0] dline_n, dline_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // behavioural reference state
    bit m_pend = 0;
    bit m_resp = 0;

    always #4 clk = ~clk;

    irq_poll_responder u_irq_poll_responder (
        .clk(clk), .rst_n(rst_n), .sel_code(sel_code), .req_strobe(req_strobe),
        .svc_clear(svc_clear), .poll_n(poll_n), .poll_bank(poll_bank),
        .req_lo_n(req_lo_n), .req_hi_n(req_hi_n), .dline_n(dline_n), .dline_oe(dline_oe)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend <= 0; m_resp <= 0;
        end else if (svc_clear) begin
            m_pend <= 0; m_resp <= 0;
        end else if (m_pend) begin
            m_resp <= (!poll_n) && (poll_bank == sel_code[3]);
        end else begin
            m_pend <= req_strobe && poll_n;
            m_resp <= 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] e_oe;
            e_oe = m_resp ? (8'd1 << sel_code[2:0]) : 8'd0;
            chk(req_lo_n == !(m_pend && !sel_code[3]), "R3 req_lo_n", req_lo_n, !(m_pend && !sel_code[3]));
            chk(req_hi_n == !(m_pend && sel_code[3]), "R3 req_hi_n", req_hi_n, !(m_pend && sel_code[3]));
            chk(dline_oe == e_oe, "R6 dline_oe", dline_oe, e_oe);
            chk(dline_n == ~e_oe, "R8 dline_n", dline_n, ~e_oe);
        end
    end

    // set inputs now, let one edge sample them, return 2 ns after it
    task automatic apply(input bit stb, input bit clr, input bit pn, input bit pb);
        req_strobe = stb; svc_clear = clr; poll_n = pn; poll_bank = pb;
        @(posedge clk); #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state, checked while reset is still held
        chk(req_lo_n && req_hi_n, "R1 request lines", {req_lo_n, req_hi_n}, 3);
        chk(dline_oe == 8'h00, "R1 dline_oe", dline_oe, 0);
        chk(dline_n == 8'hFF, "R1 dline_n", dline_n, 8'hFF);
        rst_n = 1'b1;
        @(posedge clk); #2;

        for (int s = 0; s < 16; s++) begin
            bit msb;
            logic [7:0] line;
            sel_code = 4'(s);
            msb = sel_code[3];
            line = 8'd1 << s[2:0];
            // R4: strobe during a poll is dropped
            apply(1, 0, 0, msb);
            apply(0, 0, 1, msb);
            chk(req_lo_n && req_hi_n, "R4 dropped strobe", {req_lo_n, req_hi_n}, 3);
            // R7: poll with nothing pending
            apply(0, 0, 0, msb);
            chk(dline_oe == 0, "R7 no pending", dline_oe, 0);
            // R2/R3: latch a request
            apply(1, 0, 1, msb);
            chk(msb ? (!req_hi_n && req_lo_n) : (!req_lo_n && req_hi_n),
                "R2 request latched", {req_lo_n, req_hi_n}, msb ? 2 : 1);
            // R5: held while idle inputs
            apply(0, 0, 1, msb);
            apply(1, 0, 1, msb);
            chk(!(req_lo_n && req_hi_n), "R5 request held", {req_lo_n, req_hi_n}, msb ? 2 : 1);
            // R7: wrong bank
            apply(0, 0, 0, !msb);
            chk(dline_oe == 0, "R7 wrong bank", dline_oe, 0);
            // R6: matching poll
            apply(0, 0, 0, msb);
            chk(dline_oe == line, "R6 poll line", dline_oe, line);
            chk(dline_n == ~line, "R6 poll value", dline_n, ~line);
            apply(0, 0, 0, msb);
            chk(dline_oe == line, "R6 poll held", dline_oe, line);
            // R9: poll ends, request stays
            apply(0, 0, 1, msb);
            chk(dline_oe == 0 && !(req_lo_n && req_hi_n), "R9 poll end", dline_oe, 0);
            // R9: bank mismatch mid answer
            apply(0, 0, 0, msb);
            apply(0, 0, 0, !msb);
            chk(dline_oe == 0, "R9 bank change", dline_oe, 0);
            // R9: clear during answer
            apply(0, 0, 0, msb);
            apply(0, 1, 0, msb);
            chk(dline_oe == 0 && req_lo_n && req_hi_n, "R9 clear in answer", {dline_oe, req_lo_n, req_hi_n}, 3);
            // R5: clear wins over simultaneous strobe
            apply(1, 0, 1, msb);
            apply(1, 1, 1, msb);
            chk(req_lo_n && req_hi_n, "R5 clear beats strobe", {req_lo_n, req_hi_n}, 3);
            apply(0, 0, 1, msb);
            chk(req_lo_n && req_hi_n, "R5 stays clear", {req_lo_n, req_hi_n}, 3);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule